// File: doc/BRIEF.md
# Host CPU Idle-Stuffing Controller

This block sits on the cartridge port of a small 8-bit host CPU that has 13 address lines and 8 data lines. A co-processor on the cartridge side can use it to park the host CPU in a harmless loop and later return it to a chosen address. While the CPU is parked, the block answers every read inside the cartridge window with a one-byte idle opcode. The CPU then walks its program counter forward through the window, one byte per step. It only reads, and only from the cartridge window.

The block counts how many window addresses are left before the walking program counter would leave the window. It raises a warning when that count reaches a threshold, so the co-processor can end its time slice early. When the co-processor asks for release, the block waits for the next opcode fetch. It then feeds an absolute jump to the return address one byte per fetch and hands the bus back. In the alternative idle mode, the idle opcode is a two-byte instruction. The block then puts one single-byte no-op before the jump so that the jump lands on an opcode fetch whatever phase the CPU is in.

A cartridge read counts as *fresh* when its address differs from the previous cartridge read seen since idle entry; the first cartridge read after idle entry is also fresh. A one-byte no-op re-reads the next address, so a repeated address is never treated as a new fetch.

Top module: `idle_stuffer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `state` reads 0 (pass-through) and `data_oe` is low.
- R2: In pass-through (`state` 0), `data_oe` stays low on every read and the block never drives the bus.
- R3: `idle_req` high in pass-through moves `state` to 1 (idle) at the next clock edge. While idle with `alt_idle` low, every cartridge read (addr[12] set) drives byte 0xEA with `data_oe` high.
- R4: A read with addr[12] clear never raises `data_oe`, in any state.
- R5: The remaining count loads 0x1000 minus addr[11:0] on the first fresh idle read. It falls by one on each later fresh idle read and never on a repeated address.
- R6: `budget_low` is high exactly when `state` is idle, a count has been loaded, and the count is at most `budget_threshold`.
- R7: A pulse on `release_req` while idle is held pending. It acts only at the next fresh cartridge read. With `alt_idle` low, that read returns 0x4C and `state` becomes 3. A repeat of the same address returns the same byte.
- R8: The next two fresh reads return the low byte of `resume_addr` and then {3'b000, resume_addr[12:8]}, with `state` 4 and then 5. The fresh read after those returns to pass-through (`state` 0) with `data_oe` low.
- R9: With `alt_idle` high, idle cartridge reads return 0x11.
- R10: With `alt_idle` high, the release read returns 0xEA (`state` 2). The following fresh read starts the 0x4C, low, high jump sequence.
- R11: `release_req` outside idle has no effect: the block stays in pass-through and keeps `data_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Host address; bit 12 selects the cartridge window |
| rd | input | 1 | Read strobe, one clock per bus read |
| idle_req | input | 1 | Request to park the host CPU |
| release_req | input | 1 | Request to return the CPU to `resume_addr` |
| alt_idle | input | 1 | Selects the two-byte idle opcode 0x11 instead of 0xEA; held steady while parked |
| resume_addr | input | 13 | Return address for the jump |
| budget_threshold | input | 13 | Remaining-address level at which the warning rises |
| data_out | output | 8 | Byte driven onto the data bus |
| data_oe | output | 1 | Data bus drive enable |
| budget_low | output | 1 | Remaining-budget warning |
| state | output | 3 | Sequencer state: 0 pass, 1 idle, 2 no-op, 3 jump opcode, 4 low byte, 5 high byte |

## Verification
The bench builds the block with its default 13-bit address width, so the window offset spans the full 4096 addresses. Parking at offset 0 reaches the largest budget. Parking at offset 0xF00 with a threshold of 255 reaches the exact count at which the warning rises. Both idle opcodes are exercised. In the alternative mode, the no-op's dummy read of the next address brings into reach the case where a fresh address must still advance the jump bytes correctly.

// File: rtl/isb_pkg.sv
package isb_pkg;

    typedef enum logic [2:0] {
        ST_PASS = 3'd0,
        ST_IDLE = 3'd1,
        ST_NOP  = 3'd2,
        ST_JOP  = 3'd3,
        ST_JLO  = 3'd4,
        ST_JHI  = 3'd5
    } isb_state_e;

    localparam logic [7:0] OP_NOP = 8'hEA;
    localparam logic [7:0] OP_ALT = 8'h11;
    localparam logic [7:0] OP_JMP = 8'h4C;

    // successor of a state when a fresh cartridge read arrives
    function automatic isb_state_e step_state(isb_state_e s, logic pend, logic alt);
        isb_state_e n;
        case (s)
            ST_IDLE: n = pend ? (alt ? ST_NOP : ST_JOP) : ST_IDLE;
            ST_NOP:  n = ST_JOP;
            ST_JOP:  n = ST_JLO;
            ST_JLO:  n = ST_JHI;
            ST_JHI:  n = ST_PASS;
            default: n = ST_PASS;
        endcase
        return n;
    endfunction

    // byte presented for a state
    function automatic logic [7:0] state_byte(isb_state_e s, logic alt,
                                              logic [7:0] lo, logic [7:0] hi);
        logic [7:0] b;
        case (s)
            ST_IDLE: b = alt ? OP_ALT : OP_NOP;
            ST_NOP:  b = OP_NOP;
            ST_JOP:  b = OP_JMP;
            ST_JLO:  b = lo;
            ST_JHI:  b = hi;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/isb_fetch_tag.sv
module isb_fetch_tag #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic          clear,
    output logic          cart_rd,
    output logic          fresh
);
    logic [AW-1:0] last_q;
    logic          have_q;

    assign cart_rd = rd & addr[AW-1];
    assign fresh   = cart_rd & (!have_q || (addr != last_q));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_q <= 1'b0;
            last_q <= '0;
        end else if (cart_rd) begin
            have_q <= 1'b1;
            last_q <= addr;
        end
    end
endmodule

// File: rtl/isb_budget.sv
module isb_budget #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          active,
    input  logic          fresh,
    input  logic [AW-2:0] offset,
    input  logic [AW-1:0] threshold,
    output logic          low
);
    localparam int OW = AW - 1;
    localparam logic [AW-1:0] WINDOW = AW'(1) << OW;

    logic [AW-1:0] rem_q;
    logic          loaded_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rem_q    <= '0;
            loaded_q <= 1'b0;
        end else if (active && fresh) begin
            if (!loaded_q) begin
                rem_q    <= WINDOW - {1'b0, offset};
                loaded_q <= 1'b1;
            end else if (rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign low = active & loaded_q & (rem_q <= threshold);
endmodule

// File: rtl/isb_seq.sv
module isb_seq
    import isb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_req,
    input  logic       release_req,
    input  logic       alt,
    input  logic       fresh,
    output isb_state_e state_q,
    output isb_state_e shown,
    output logic       enter
);
    logic pend_q;

    assign enter = (state_q == ST_PASS) && idle_req;
    assign shown = fresh ? step_state(state_q, pend_q, alt) : state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PASS;
            pend_q  <= 1'b0;
        end else begin
            if (enter)
                state_q <= ST_IDLE;
            else if (fresh)
                state_q <= shown;

            if (state_q != ST_IDLE || (fresh && shown != ST_IDLE))
                pend_q <= 1'b0;
            else if (release_req)
                pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/idle_stuffer.sv
module idle_stuffer
    import isb_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          idle_req,
    input  logic          release_req,
    input  logic          alt_idle,
    input  logic [AW-1:0] resume_addr,
    input  logic [AW-1:0] budget_threshold,
    output logic [7:0]    data_out,
    output logic          data_oe,
    output logic          budget_low,
    output logic [2:0]    state
);
    localparam int HB = AW - 8;

    logic       cart_rd, fresh, enter;
    isb_state_e st_q, shown;
    logic [7:0] lo_b, hi_b;

    assign lo_b = resume_addr[7:0];
    assign hi_b = {{(8-HB){1'b0}}, resume_addr[AW-1:8]};

    isb_fetch_tag #(.AW(AW)) u_tag (
        .clk(clk), .rst(rst), .rd(rd), .addr(addr), .clear(enter),
        .cart_rd(cart_rd), .fresh(fresh)
    );

    isb_seq u_seq (
        .clk(clk), .rst(rst), .idle_req(idle_req), .release_req(release_req),
        .alt(alt_idle), .fresh(fresh), .state_q(st_q), .shown(shown),
        .enter(enter)
    );

    isb_budget #(.AW(AW)) u_bud (
        .clk(clk), .rst(rst), .clear(enter), .active(st_q == ST_IDLE),
        .fresh(fresh), .offset(addr[AW-2:0]), .threshold(budget_threshold),
        .low(budget_low)
    );

    assign data_oe  = cart_rd && (shown != ST_PASS);
    assign data_out = data_oe ? state_byte(shown, alt_idle, lo_b, hi_b) : 8'h00;
    assign state    = st_q;
endmodule

// File: rtl/isb_checker.sv
module isb_checker #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          rd,
    input logic [7:0]    data_out,
    input logic          data_oe,
    input logic          budget_low,
    input logic [2:0]    state
);
    a_r1_reset_pass: assert property (@(posedge clk) rst |=> (state == 3'd0));

    a_r2_pass_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd0) |-> !data_oe);

    a_r4_no_drive_outside: assert property (@(posedge clk) disable iff (rst)
        !addr[AW-1] |-> !data_oe);

    a_r6_low_only_idle: assert property (@(posedge clk) disable iff (rst)
        budget_low |-> (state == 3'd1));

    a_r3_idle_bytes: assert property (@(posedge clk) disable iff (rst)
        (data_oe && state == 3'd1) |->
        (data_out == 8'hEA || data_out == 8'h11 || data_out == 8'h4C));

    a_r8_lo_follows_op: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == 3'd3 && state != 3'd3) |-> (state == 3'd4));

    a_r8_hi_follows_lo: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == 3'd4 && state != 3'd4) |-> (state == 3'd5));
endmodule

bind idle_stuffer isb_checker #(.AW(AW)) u_isb_chk (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .data_out(data_out),
    .data_oe(data_oe), .budget_low(budget_low), .state(state)
);

// File: tb/test_idle_stuffer.sv
module test_idle_stuffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr = '0;
    logic        rd = 1'b0;
    logic        idle_req = 1'b0;
    logic        release_req = 1'b0;
    logic        alt_idle = 1'b0;
    logic [12:0] resume_addr = 13'h1ABC;
    logic [12:0] budget_threshold = 13'd100;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        budget_low;
    logic [2:0]  state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       oe;
        logic [7:0] data;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    event smp;

    always #5 clk = ~clk;

    idle_stuffer i_idle_stuffer (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .idle_req(idle_req),
        .release_req(release_req), .alt_idle(alt_idle), .resume_addr(resume_addr),
        .budget_threshold(budget_threshold), .data_out(data_out), .data_oe(data_oe),
        .budget_low(budget_low), .state(state)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: pops expected read results and compares
    initial begin
        forever begin
            @(smp);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " oe"}, {15'd0, data_oe}, {15'd0, e.oe});
                if (e.oe)
                    check({e.req, " data"}, {8'd0, data_out}, {8'd0, e.data});
            end
        end
    end

    // driver: one bus read with its expected result
    task automatic bus_read(logic [12:0] a, logic eoe, logic [7:0] ed, string req);
        exp_t e;
        e.oe = eoe; e.data = ed; e.req = req;
        @(negedge clk);
        addr = a;
        rd = 1'b1;
        exp_q.push_back(e);
        #1;
        -> smp;
        @(posedge clk);
        #1;
        rd = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(posedge clk);
        #1;
        s = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", {13'd0, state}, 16'd0);
        check("R1 reset oe", {15'd0, data_oe}, 16'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 state after release", {13'd0, state}, 16'd0);

        // R2: pass-through never drives
        bus_read(13'h1800, 1'b0, 8'h00, "R2 pass read");
        // R11: release outside idle ignored
        pulse(release_req);
        bus_read(13'h1200, 1'b0, 8'h00, "R11 release in pass");
        check("R11 state", {13'd0, state}, 16'd0);

        // R3 entry with 0xEA
        pulse(idle_req);
        check("R3 enter idle", {13'd0, state}, 16'd1);
        bus_read(13'h1000, 1'b1, 8'hEA, "R3 idle byte");
        bus_read(13'h1000, 1'b1, 8'hEA, "R3 repeat idle byte");
        bus_read(13'h0080, 1'b0, 8'h00, "R4 non-cart read");
        check("R6 low off at full budget", {15'd0, budget_low}, 16'd0);
        bus_read(13'h1001, 1'b1, 8'hEA, "R3 next idle byte");
        pulse(release_req);
        bus_read(13'h1001, 1'b1, 8'hEA, "R7 repeat before boundary");
        check("R7 still idle", {13'd0, state}, 16'd1);
        bus_read(13'h1002, 1'b1, 8'h4C, "R7 jump opcode");
        check("R7 state jop", {13'd0, state}, 16'd3);
        bus_read(13'h1002, 1'b1, 8'h4C, "R7 repeat jump opcode");
        bus_read(13'h1003, 1'b1, 8'hBC, "R8 low byte");
        check("R8 state lo", {13'd0, state}, 16'd4);
        bus_read(13'h1004, 1'b1, 8'h1A, "R8 high byte");
        check("R8 state hi", {13'd0, state}, 16'd5);
        bus_read(13'h1ABC, 1'b0, 8'h00, "R8 resumed");
        check("R8 state pass", {13'd0, state}, 16'd0);

        // budget near end of window
        budget_threshold = 13'd255;
        pulse(idle_req);
        bus_read(13'h1F00, 1'b1, 8'hEA, "R5 load at 0xF00");
        check("R6 256 above threshold", {15'd0, budget_low}, 16'd0);
        bus_read(13'h1F00, 1'b1, 8'hEA, "R5 repeat");
        check("R5 no decrement on repeat", {15'd0, budget_low}, 16'd0);
        bus_read(13'h1F01, 1'b1, 8'hEA, "R5 fresh");
        check("R6 low at 255", {15'd0, budget_low}, 16'd1);
        pulse(release_req);
        bus_read(13'h1F02, 1'b1, 8'h4C, "R7 jump opcode 2");
        check("R6 low drops outside idle", {15'd0, budget_low}, 16'd0);
        bus_read(13'h1F03, 1'b1, 8'hBC, "R8 low byte 2");
        bus_read(13'h1F04, 1'b1, 8'h1A, "R8 high byte 2");
        bus_read(13'h1ABC, 1'b0, 8'h00, "R8 resumed 2");

        // alternative opcode
        alt_idle = 1'b1;
        budget_threshold = 13'd0;
        resume_addr = 13'h1234;
        pulse(idle_req);
        bus_read(13'h1100, 1'b1, 8'h11, "R9 alt idle byte");
        bus_read(13'h1101, 1'b1, 8'h11, "R9 alt operand byte");
        pulse(release_req);
        bus_read(13'h1102, 1'b1, 8'hEA, "R10 nop first");
        check("R10 state nop", {13'd0, state}, 16'd2);
        bus_read(13'h1103, 1'b1, 8'h4C, "R10 dummy read jop");
        bus_read(13'h1103, 1'b1, 8'h4C, "R10 jump opcode");
        bus_read(13'h1104, 1'b1, 8'h34, "R10 low byte");
        bus_read(13'h1105, 1'b1, 8'h12, "R10 high byte");
        bus_read(13'h1234, 1'b0, 8'h00, "R10 resumed");
        check("R10 state pass", {13'd0, state}, 16'd0);
        alt_idle = 1'b0;

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule